// File: doc/BRIEF.md
# Two-Channel Digital Volume Stage with Static-Run Muting

This block scales a stereo stream of signed 24-bit samples by a gain taken from two 8-bit codes: one shared by both channels and one per channel. Each code counts attenuation in half-decibel steps from a top gain of +24 dB. Code 30h is unity, 2Ah is +3 dB (the suggested power-on setting for the shared code), FEh is -103 dB, and FFh silences the output outright. The two codes' decibel values are summed before the sum becomes a linear multiplier. The product is clipped to the 24-bit range and registered. The result appears one clock after the qualifying `in_valid` strobe.

Each channel also has a run tracker. It detects long stretches of identical "silent" samples, meaning all zeros or all ones (-1). When automatic muting is enabled, it forces that channel to zero. The tracker is a state machine with five states. `AM_LIVE` is the state with no run in progress. `AM_RUN_ZERO` and `AM_RUN_ONES` count a run in progress. `AM_MUTE_ZERO` and `AM_MUTE_ONES` mean the run has reached the mute length. The transitions are as follows:
- A static sample moves `AM_LIVE` to the run state of its polarity.
- A same-polarity sample in a run state increments the count. When the count reaches the run length, it moves the machine to the matching mute state.
- An opposite-polarity sample in any run or mute state restarts counting at one, in the other polarity's run state.
- Any non-static sample returns the machine to `AM_LIVE`.
- A same-polarity sample in a mute state keeps the machine there.

The tracker runs whether or not muting is enabled. The enable only gates its effect. Each channel also has a manual mute input.

Top module: `vol_gain_stage`

## Requirements
- R1: `out_valid` is high exactly one clock after each cycle with `in_valid` high. While `in_valid` is low, `out_left` and `out_right` keep their last values.
- R2: A code value c below FFh stands for (24 - c/2) dB. With one code at 30h, the other code alone sets the gain: 30h gives an exact copy of the input, 2Ah gives +3 dB, 00h gives +24 dB and FEh gives -103 dB.
- R3: The attenuation in half-dB steps is a = master_code + channel_code. Write a = 12q + k with 0 <= k < 12. The output is floor(x * M(k) / 2^(7+q)), where M(k) = round(32768 * 2^(-k/12)). Every 12 half-dB steps is therefore exactly one factor of two, and a zero input always gives zero.
- R4: If either the shared code or a channel's own code is FFh, that channel's output is 0.
- R5: The manual mute of one channel forces that channel's output to 0 and has no effect on the other channel.
- R6: Results beyond the signed 24-bit range are clipped to 7FFFFFh or 800000h.
- R7: With automatic muting enabled, a sample that is the 8192nd or a later member of an unbroken run of identical samples (all 0, or all -1) on a channel produces 0 on that channel.
- R8: The first non-static sample after a muted run is scaled normally, with no delay.
- R9: A change between 0 and -1 restarts the run count at one, so a mixed run of 0 and -1 samples never mutes.
- R10: Run tracking and muting are separate per channel. A run on one channel never mutes the other.
- R11: With automatic muting disabled, static samples are scaled normally, but run counting continues. Enabling muting during a run that is already 8192 or more samples long mutes the very next sample of that run.
- R12: During and after reset, `out_valid` is low and both outputs are 0 until the first valid sample is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| master_code | input | 8 | Shared volume code, 0.5 dB per step, FFh silences |
| left_code | input | 8 | Left channel volume code |
| right_code | input | 8 | Right channel volume code |
| left_mute | input | 1 | Manual mute for the left channel |
| right_mute | input | 1 | Manual mute for the right channel |
| auto_mute_en | input | 1 | Enables muting on long static runs |
| out_valid | output | 1 | Registered sample strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
The assertions assume that codes, mute inputs and the auto-mute enable change only on cycles when the values they affect are re-evaluated. They also assume that a sample presented without `in_valid` is ignored. The stimulus therefore changes settings only between samples, and it fills the idle cycles with random sample data so that a block that wrongly consumed them would diverge. The run-length checks take for granted that only strobed samples advance a run. For that reason, the long static runs are interleaved with idle cycles, and they are fed on one channel while the other channel carries random data.

// File: rtl/vol_pkg.sv
package vol_pkg;

    // Half-dB steps per factor of two in gain
    localparam int OCT_STEPS   = 12;
    localparam int STEP_W      = 4;
    // Fraction bits of the in-octave multiplier
    localparam int MANT_FRAC   = 15;
    localparam int MANT_W      = 16;
    // Octaves of gain above unity when both codes are zero
    localparam int HEADROOM_OCT = 8;

    typedef enum logic [2:0] {
        AM_LIVE,
        AM_RUN_ZERO,
        AM_RUN_ONES,
        AM_MUTE_ZERO,
        AM_MUTE_ONES
    } am_state_e;

    // round(32768 * 2^(-k/12)) for k = 0..11
    function automatic logic [MANT_W-1:0] oct_mantissa(input logic [STEP_W-1:0] k);
        logic [MANT_W-1:0] m;
        unique case (k)
            4'd0:    m = 16'd32768;
            4'd1:    m = 16'd30929;
            4'd2:    m = 16'd29193;
            4'd3:    m = 16'd27554;
            4'd4:    m = 16'd26008;
            4'd5:    m = 16'd24548;
            4'd6:    m = 16'd23170;
            4'd7:    m = 16'd21870;
            4'd8:    m = 16'd20643;
            4'd9:    m = 16'd19484;
            4'd10:   m = 16'd18390;
            4'd11:   m = 16'd17358;
            default: m = 16'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vol_code_decoder.sv
module vol_code_decoder
    import vol_pkg::*;
#(
    parameter int CODE_W = 8,
    localparam int ATT_W = CODE_W + 1,
    localparam int MAX_ATT = 2 * ((1 << CODE_W) - 1),
    localparam int OCT_W = $clog2(MAX_ATT / OCT_STEPS + 1)
) (
    input  logic [CODE_W-1:0] master_code,
    input  logic [CODE_W-1:0] chan_code,
    output logic              hard_mute,
    output logic [OCT_W-1:0]  oct,
    output logic [STEP_W-1:0] step
);
    localparam logic [CODE_W-1:0] MUTE_CODE = {CODE_W{1'b1}};

    logic [ATT_W-1:0] att;

    always_comb begin
        att       = {1'b0, master_code} + {1'b0, chan_code};
        hard_mute = (master_code == MUTE_CODE) || (chan_code == MUTE_CODE);
        oct       = OCT_W'(att / ATT_W'(OCT_STEPS));
        step      = STEP_W'(att % ATT_W'(OCT_STEPS));
    end

endmodule

// File: rtl/vol_automute_fsm.sv
module vol_automute_fsm
    import vol_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int RUN_LEN = 8192,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp,
    input  logic              enable,
    output logic              mute_now
);
    localparam logic [CNT_W-1:0] RUN_CNT = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam bit SHORT_RUN = (RUN_LEN <= 1);

    am_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             is_zero, is_ones, hit_len;

    assign is_zero = (smp == '0);
    assign is_ones = &smp;
    assign hit_len = (cnt_q + ONE) >= RUN_CNT;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AM_LIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (smp_valid) begin
            unique case (state_q)
                AM_LIVE, AM_MUTE_ZERO, AM_MUTE_ONES,
                AM_RUN_ZERO, AM_RUN_ONES: begin
                    if (!is_zero && !is_ones) begin
                        state_d = AM_LIVE;
                        cnt_d   = '0;
                    end else if (is_zero) begin
                        if (state_q == AM_MUTE_ZERO) begin
                            state_d = AM_MUTE_ZERO;
                        end else if (state_q == AM_RUN_ZERO) begin
                            state_d = hit_len ? AM_MUTE_ZERO : AM_RUN_ZERO;
                            cnt_d   = hit_len ? RUN_CNT : cnt_q + ONE;
                        end else begin
                            state_d = SHORT_RUN ? AM_MUTE_ZERO : AM_RUN_ZERO;
                            cnt_d   = ONE;
                        end
                    end else begin
                        if (state_q == AM_MUTE_ONES) begin
                            state_d = AM_MUTE_ONES;
                        end else if (state_q == AM_RUN_ONES) begin
                            state_d = hit_len ? AM_MUTE_ONES : AM_RUN_ONES;
                            cnt_d   = hit_len ? RUN_CNT : cnt_q + ONE;
                        end else begin
                            state_d = SHORT_RUN ? AM_MUTE_ONES : AM_RUN_ONES;
                            cnt_d   = ONE;
                        end
                    end
                end
                default: begin
                    state_d = AM_LIVE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs: the sample that completes or extends a full run is muted
    always_comb begin
        unique case (state_d)
            AM_MUTE_ZERO, AM_MUTE_ONES: mute_now = enable && smp_valid;
            default:                    mute_now = 1'b0;
        endcase
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RUN_CNT);

    p_live_on_motion_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !is_zero && !is_ones) |=> (state_q == AM_LIVE));

    p_mute_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!SHORT_RUN && $rose(state_q == AM_MUTE_ZERO)) |-> ($past(state_q) == AM_RUN_ZERO));

    p_polarity_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!SHORT_RUN && smp_valid && is_ones &&
         (state_q == AM_RUN_ZERO || state_q == AM_MUTE_ZERO)) |=> (state_q == AM_RUN_ONES && cnt_q == ONE));

endmodule

// File: rtl/vol_gain_apply.sv
module vol_gain_apply
    import vol_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int OCT_W  = 6,
    localparam int PROD_W = DATA_W + MANT_W + 1,
    localparam int SH_W   = $clog2(PROD_W + (1 << OCT_W))
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic [STEP_W-1:0]        step,
    input  logic [OCT_W-1:0]         oct,
    input  logic                     kill,
    output logic signed [DATA_W-1:0] result
);
    localparam int BASE_SHIFT = MANT_FRAC - HEADROOM_OCT;
    localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [PROD_W-1:0] smp_ext, mant_ext, prod, scaled;
    logic [SH_W-1:0]          shamt;
    logic [PROD_W-DATA_W:0]   upper;
    logic                     ovf;

    always_comb begin
        smp_ext  = PROD_W'(sample);
        mant_ext = PROD_W'($signed({1'b0, oct_mantissa(step)}));
        prod     = smp_ext * mant_ext;
        shamt    = SH_W'(BASE_SHIFT) + SH_W'(oct);
        scaled   = prod >>> shamt;
        upper    = scaled[PROD_W-1:DATA_W-1];
        ovf      = !((&upper) || (~|upper));
        if (kill)
            result = '0;
        else if (ovf)
            result = scaled[PROD_W-1] ? NEG_MAX : POS_MAX;
        else
            result = scaled[DATA_W-1:0];
    end

endmodule

// File: rtl/vol_gain_stage.sv
module vol_gain_stage
    import vol_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int CODE_W  = 8,
    parameter int RUN_LEN = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [CODE_W-1:0] master_code,
    input  logic [CODE_W-1:0] left_code,
    input  logic [CODE_W-1:0] right_code,
    input  logic              left_mute,
    input  logic              right_mute,
    input  logic              auto_mute_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    localparam int NUM_CH  = 2;
    localparam int MAX_ATT = 2 * ((1 << CODE_W) - 1);
    localparam int OCT_W   = $clog2(MAX_ATT / OCT_STEPS + 1);
    localparam logic [CODE_W-1:0] MUTE_CODE  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] UNITY_CODE = CODE_W'(HEADROOM_OCT * OCT_STEPS / 2);

    logic [DATA_W-1:0]        ch_in   [NUM_CH];
    logic [CODE_W-1:0]        ch_code [NUM_CH];
    logic                     ch_man  [NUM_CH];
    logic signed [DATA_W-1:0] ch_res  [NUM_CH];

    assign ch_in[0]   = in_left;
    assign ch_in[1]   = in_right;
    assign ch_code[0] = left_code;
    assign ch_code[1] = right_code;
    assign ch_man[0]  = left_mute;
    assign ch_man[1]  = right_mute;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              hard_mute, am_mute;
        logic [OCT_W-1:0]  oct;
        logic [STEP_W-1:0] step;

        vol_code_decoder #(.CODE_W(CODE_W)) i_dec (
            .master_code (master_code),
            .chan_code   (ch_code[c]),
            .hard_mute   (hard_mute),
            .oct         (oct),
            .step        (step)
        );

        vol_automute_fsm #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) i_am (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (in_valid),
            .smp       (ch_in[c]),
            .enable    (auto_mute_en),
            .mute_now  (am_mute)
        );

        vol_gain_apply #(.DATA_W(DATA_W), .OCT_W(OCT_W)) i_gain (
            .sample (ch_in[c]),
            .step   (step),
            .oct    (oct),
            .kill   (hard_mute | ch_man[c] | am_mute),
            .result (ch_res[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= ch_res[0];
                out_right <= ch_res[1];
            end
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    p_unity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && master_code == UNITY_CODE && left_code == UNITY_CODE &&
         !left_mute && !auto_mute_en) |=> (out_left == $past(in_left)));

    p_zero_stays_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_left == '0) |=> (out_left == '0));

    p_code_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && master_code == MUTE_CODE) |=> (out_left == '0 && out_right == '0));

    p_manual_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && right_mute) |=> (out_right == '0));

endmodule

// File: tb/test_vol_gain_stage.sv
module test_vol_gain_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [7:0]  master_code = 8'h30, left_code = 8'h30, right_code = 8'h30;
    logic        left_mute = 1'b0, right_mute = 1'b0, auto_mute_en = 1'b1;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    always #4 clk = ~clk;

    vol_gain_stage i_vol_gain_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .master_code(master_code), .left_code(left_code), .right_code(right_code),
        .left_mute(left_mute), .right_mute(right_mute), .auto_mute_en(auto_mute_en),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    int    checks = 0, failures = 0, n_fed = 0;
    string tag = "R12";

    // reference state
    int ex_valid = 0;
    int ex [2] = '{0, 0};
    int run [2] = '{0, 0};
    int last [2] = '{0, 0};

    function automatic int ref_level(int x, int mc, int cc, bit silenced);
        int att, q, k, mant;
        longint p, s;
        if (mc == 255 || cc == 255 || silenced) return 0;
        att  = mc + cc;
        q    = att / 12;
        k    = att % 12;
        mant = $rtoi(32768.0 * (2.0 ** (-real'(k) / 12.0)) + 0.5);
        p    = longint'(x) * longint'(mant);
        s    = p >>> (7 + q);
        if (s > 64'sd8388607)  s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        return int'(s);
    endfunction

    function automatic int rnd24();
        logic [23:0] v;
        v = 24'($urandom);
        return int'($signed(v));
    endfunction

    always @(posedge clk) begin
        int smp [2];
        int cc [2];
        bit man [2];
        if (!rst_n) begin
            ex_valid = 0; ex[0] = 0; ex[1] = 0;
            run[0] = 0; run[1] = 0;
        end else begin
            ex_valid = in_valid ? 1 : 0;
            if (in_valid) begin
                smp[0] = int'($signed(in_left));  smp[1] = int'($signed(in_right));
                cc[0]  = int'(left_code);         cc[1]  = int'(right_code);
                man[0] = left_mute;               man[1] = right_mute;
                for (int c = 0; c < 2; c++) begin
                    if (smp[c] == 0 || smp[c] == -1) begin
                        if (run[c] > 0 && last[c] == smp[c]) run[c]++;
                        else begin run[c] = 1; last[c] = smp[c]; end
                    end else run[c] = 0;
                    ex[c] = ref_level(smp[c], int'(master_code), cc[c],
                                      man[c] || (auto_mute_en && run[c] >= 8192));
                end
            end
        end
        #2;
        checks++;
        if (int'(out_valid) != ex_valid) begin
            failures++;
            $display("FAIL %s out_valid actual=%0d expected=%0d", tag, out_valid, ex_valid);
        end
        checks++;
        if (int'($signed(out_left)) != ex[0]) begin
            failures++;
            $display("FAIL %s out_left actual=%0d expected=%0d", tag, $signed(out_left), ex[0]);
        end
        checks++;
        if (int'($signed(out_right)) != ex[1]) begin
            failures++;
            $display("FAIL %s out_right actual=%0d expected=%0d", tag, $signed(out_right), ex[1]);
        end
    end

    // one strobed sample; every fourth is followed by an idle cycle with junk data (R1)
    task automatic feed(input int l, input int r);
        @(negedge clk);
        in_valid = 1'b1; in_left = 24'(l); in_right = 24'(r);
        n_fed++;
        if (n_fed % 4 == 0) begin
            @(negedge clk);
            in_valid = 1'b0; in_left = 24'($urandom); in_right = 24'($urandom);
        end
    endtask

    task automatic settle();
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int mlist [7] = '{8'h00, 8'h2A, 8'h30, 8'h31, 8'h3C, 8'h60, 8'hFE};
        int clist [4] = '{8'h00, 8'h17, 8'h2A, 8'hFE};
        // R12: reset state observed for several cycles
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1, R2: shared code sweep at unity channel code
        tag = "R2";
        foreach (mlist[i]) begin
            master_code = 8'(mlist[i]);
            for (int n = 0; n < 6; n++) feed(rnd24() >>> 6, rnd24() >>> 6);
        end
        master_code = 8'h30;
        foreach (clist[i]) begin
            left_code = 8'(clist[i]); right_code = 8'(clist[3 - i]);
            for (int n = 0; n < 6; n++) feed(rnd24() >>> 6, rnd24());
        end

        // R3: additive codes, octave steps and zero input
        tag = "R3";
        master_code = 8'h10; left_code = 8'h20; right_code = 8'h3C;
        for (int n = 0; n < 8; n++) feed(rnd24(), rnd24());
        master_code = 8'h80; left_code = 8'h7F; right_code = 8'h05;
        for (int n = 0; n < 8; n++) feed(rnd24(), 0);
        feed(8388607, -8388608);

        // R4: silence code on either code
        tag = "R4";
        master_code = 8'h30; left_code = 8'hFF; right_code = 8'h30;
        for (int n = 0; n < 5; n++) feed(rnd24(), rnd24());
        master_code = 8'hFF; left_code = 8'h30;
        for (int n = 0; n < 5; n++) feed(rnd24(), rnd24());
        master_code = 8'h30;

        // R5: manual mute on one side only
        tag = "R5";
        left_mute = 1'b1;
        for (int n = 0; n < 5; n++) feed(rnd24(), rnd24());
        left_mute = 1'b0; right_mute = 1'b1;
        for (int n = 0; n < 5; n++) feed(rnd24(), rnd24());
        right_mute = 1'b0;

        // R6: clipping at +48 dB total
        tag = "R6";
        master_code = 8'h00; left_code = 8'h00; right_code = 8'h00;
        feed(8388607, -8388608);
        feed(40000, -40000);
        feed(1000, -1000);
        feed(32767, -32768);
        for (int n = 0; n < 6; n++) feed(rnd24(), rnd24() >>> 12);
        master_code = 8'h30; left_code = 8'h30; right_code = 8'h30;
        settle();

        // R7, R10: long -1 run on left, random traffic on right
        tag = "R7";
        for (int n = 0; n < 8195; n++) feed(-1, rnd24() | 1);

        // R8: a moving sample ends the mute at once
        tag = "R8";
        feed(5, rnd24());
        feed(-1, rnd24());
        feed(-1, rnd24());

        // R9: polarity changes restart the count
        tag = "R9";
        for (int n = 0; n < 8000; n++) feed(-1, 0);
        feed(0, 0);
        for (int n = 0; n < 300; n++) feed(-1, 0);
        for (int n = 0; n < 5; n++) feed(rnd24(), -1);
        settle();

        // R11: disabled muting keeps counting, enabling mid-run mutes at once
        tag = "R11";
        auto_mute_en = 1'b0;
        for (int n = 0; n < 8200; n++) feed(-1, rnd24());
        auto_mute_en = 1'b1;
        for (int n = 0; n < 4; n++) feed(-1, rnd24());
        feed(77, rnd24());
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL %s watchdog actual=running expected=finished", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule